// File: doc/BRIEF.md
# Hardware Cursor Overlay Merger

This block sits on the video output path of a 256x256 display. It places a small hardware cursor over the pixel stream as pixels are scanned out. The cursor image is held in a private pointer RAM with one byte per cursor pixel. A CPU-side port loads that RAM and the cursor position. For each incoming framebuffer pixel the block checks whether the pixel lies inside the cursor window. If it does, the block reads the matching cursor byte and mixes its colour with the framebuffer colour, weighted by the cursor's two-bit alpha. Because the merge happens on the output path, software never has to redraw the frame underneath the pointer.

There are two window sizes. The base mode uses an 8x8 cursor. The enlarged mode uses a 16x16 cursor. The enlarged mode can also magnify an 8x8 legacy image by 2 in both axes. The X/Y position is taken into use only at a frame-start strobe, so a position change made in the middle of a frame never splits the cursor.

Top module: `ptr_overlay`

## Requirements
- R1: While rst_ni is low, pix_valid_o and pix_rgb_o are both 0.
- R2: Every input pixel with pix_valid_i high produces exactly one output pixel with pix_valid_o high on the following clock cycle. Pixel order is kept and no extra output pixels appear.
- R3: While cur_en_i is low, the output colour equals the input colour.
- R4: The cursor window covers the columns pos_x to pos_x+S-1 and the rows pos_y to pos_y+S-1, where S is 8 in base mode and 16 in big mode. Coordinates do not wrap past 255. A pixel outside the window passes through unchanged.
- R5: In base mode (cur_big_i low), the window pixel at column offset c and row offset r reads pointer RAM address r*8+c. A RAM byte holds alpha in [7:6], red in [5:4], green in [3:2] and blue in [1:0]. Colour words on the pixel ports hold red in [5:4], green in [3:2] and blue in [1:0].
- R6: Alpha 0 outputs the cursor colour only. Alpha 3 outputs the framebuffer colour only.
- R7: Alpha 1 outputs floor((2*cur+fb)/3) for each channel. Alpha 2 outputs floor((cur+2*fb)/3) for each channel.
- R8: In big mode with cur_dbl_i low, offset (c, r) reads address r*16+c.
- R9: In big mode with cur_dbl_i high, offset (c, r) reads address (r/2)*8+(c/2). In base mode, cur_dbl_i has no effect.
- R10: The values on pos_x_i and pos_y_i are loaded only in a cycle where frame_start_i is high. They apply from the next cycle onward. Changes on these inputs at any other time have no effect.
- R11: A pointer RAM write can happen in any cycle. If a window pixel reads the address being written in that same cycle, the pixel uses the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_en_i | input | 1 | Cursor enable |
| cur_big_i | input | 1 | Selects the 16x16 window |
| cur_dbl_i | input | 1 | Doubles an 8x8 image in big mode |
| frame_start_i | input | 1 | Frame-start strobe that loads the position |
| pos_x_i | input | 8 | Cursor left column |
| pos_y_i | input | 8 | Cursor top row |
| ram_we_i | input | 1 | Pointer RAM write enable |
| ram_addr_i | input | 8 | Pointer RAM byte address |
| ram_wdata_i | input | 8 | Pointer RAM write byte (alpha/red/green/blue) |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_i | input | 8 | Input pixel column |
| pix_y_i | input | 8 | Input pixel row |
| pix_rgb_i | input | 6 | Framebuffer colour |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_rgb_o | output | 6 | Merged colour |

## Verification
The pointer RAM is filled with an address-dependent pattern. Rasters are then scanned across and around the window in each mode, so any addressing slip, such as a swapped axis, a wrong stride or a missing halving, shows up as a wrong colour at a known offset. Bytes with each of the four alpha values are placed against chosen framebuffer colours, which separates the two blend ratios from each other and from the pure-cursor and pure-framebuffer cases. Edge placements at column 250 and row 250 test clipping without wrap. A position change without a frame-start strobe, and a write that collides with a read, test the two timing rules.

// File: rtl/ptr_ovl_pkg.sv
package ptr_ovl_pkg;

  typedef struct packed {
    logic [1:0] a;
    logic [1:0] r;
    logic [1:0] g;
    logic [1:0] b;
  } argb_t;

  // Per-channel weighted mix; a=0 cursor, a=3 frame
  function automatic logic [1:0] mix_ch(input logic [1:0] a, input logic [1:0] c,
                                        input logic [1:0] f);
    logic [3:0] s;
    logic [3:0] q;
    s = '0;
    q = '0;
    unique case (a)
      2'd0: q = {2'b00, c};
      2'd1: begin s = {1'b0, c, 1'b0} + {2'b00, f}; q = s / 4'd3; end
      2'd2: begin s = {2'b00, c} + {1'b0, f, 1'b0}; q = s / 4'd3; end
      default: q = {2'b00, f};
    endcase
    return q[1:0];
  endfunction

endpackage

// File: rtl/ptr_ram.sv
module ptr_ram #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // CPU write wins over a same-cycle read
  always_comb begin
    if (we_i && (waddr_i == raddr_i)) rdata_o = wdata_i;
    else                              rdata_o = mem_q[raddr_i];
  end
endmodule

// File: rtl/ptr_window.sv
module ptr_window #(
  parameter int CW = 8,
  parameter int SL = 3,
  localparam int AW = 2 * (SL + 1)
) (
  input  logic          en_i,
  input  logic          big_i,
  input  logic          dbl_i,
  input  logic [CW-1:0] pos_x_i,
  input  logic [CW-1:0] pos_y_i,
  input  logic [CW-1:0] pix_x_i,
  input  logic [CW-1:0] pix_y_i,
  output logic          hit_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [CW:0] SIDE_S = (CW+1)'(1) << SL;
  localparam logic [CW:0] SIDE_L = (CW+1)'(1) << (SL + 1);

  logic [CW:0] dx, dy, side;
  logic        in_x, in_y;

  always_comb begin
    dx   = {1'b0, pix_x_i} - {1'b0, pos_x_i};
    dy   = {1'b0, pix_y_i} - {1'b0, pos_y_i};
    side = big_i ? SIDE_L : SIDE_S;
    in_x = !dx[CW] && (dx < side);
    in_y = !dy[CW] && (dy < side);
    hit_o = en_i && in_x && in_y;
  end

  always_comb begin
    if (big_i && dbl_i) addr_o = AW'({dy[SL:1], dx[SL:1]});
    else if (big_i)     addr_o = {dy[SL:0], dx[SL:0]};
    else                addr_o = AW'({dy[SL-1:0], dx[SL-1:0]});
  end
endmodule

// File: rtl/ptr_blend.sv
module ptr_blend
  import ptr_ovl_pkg::*;
(
  input  logic       hit_i,
  input  logic [7:0] cur_i,
  input  logic [5:0] fb_i,
  output logic [5:0] rgb_o
);
  argb_t      cur;
  logic [5:0] mixed;

  assign cur = argb_t'(cur_i);

  for (genvar ch = 0; ch < 3; ch++) begin : g_ch
    assign mixed[2*ch +: 2] = mix_ch(cur.a, cur_i[2*ch +: 2], fb_i[2*ch +: 2]);
  end

  assign rgb_o = hit_i ? mixed : fb_i;
endmodule

// File: rtl/ptr_overlay.sv
module ptr_overlay #(
  parameter int CW = 8,
  parameter int SL = 3,
  localparam int AW = 2 * (SL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cur_en_i,
  input  logic          cur_big_i,
  input  logic          cur_dbl_i,
  input  logic          frame_start_i,
  input  logic [CW-1:0] pos_x_i,
  input  logic [CW-1:0] pos_y_i,
  input  logic          ram_we_i,
  input  logic [AW-1:0] ram_addr_i,
  input  logic [7:0]    ram_wdata_i,
  input  logic          pix_valid_i,
  input  logic [CW-1:0] pix_x_i,
  input  logic [CW-1:0] pix_y_i,
  input  logic [5:0]    pix_rgb_i,
  output logic          pix_valid_o,
  output logic [5:0]    pix_rgb_o
);
  logic [CW-1:0] pos_x_q, pos_y_q;
  logic          hit_w;
  logic [AW-1:0] rd_addr_w;
  logic [7:0]    cur_px_w;
  logic [5:0]    mix_w;

  // Position only moves at frame start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_x_q <= '0;
      pos_y_q <= '0;
    end else if (frame_start_i) begin
      pos_x_q <= pos_x_i;
      pos_y_q <= pos_y_i;
    end
  end

  ptr_window #(.CW(CW), .SL(SL)) u_win (
    .en_i   (cur_en_i),
    .big_i  (cur_big_i),
    .dbl_i  (cur_dbl_i),
    .pos_x_i(pos_x_q),
    .pos_y_i(pos_y_q),
    .pix_x_i(pix_x_i),
    .pix_y_i(pix_y_i),
    .hit_o  (hit_w),
    .addr_o (rd_addr_w)
  );

  ptr_ram #(.AW(AW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we_i),
    .waddr_i(ram_addr_i),
    .wdata_i(ram_wdata_i),
    .raddr_i(rd_addr_w),
    .rdata_o(cur_px_w)
  );

  ptr_blend u_blend (
    .hit_i(hit_w),
    .cur_i(cur_px_w),
    .fb_i (pix_rgb_i),
    .rgb_o(mix_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_rgb_o   <= '0;
    end else begin
      pix_valid_o <= pix_valid_i;
      pix_rgb_o   <= mix_w;
    end
  end
endmodule

// File: rtl/ptr_overlay_chk.sv
module ptr_overlay_chk #(
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cur_en_i,
  input logic          frame_start_i,
  input logic [CW-1:0] pos_x_i,
  input logic [CW-1:0] pos_y_i,
  input logic          pix_valid_i,
  input logic [5:0]    pix_rgb_i,
  input logic          pix_valid_o,
  input logic [5:0]    pix_rgb_o,
  input logic          hit_i,
  input logic [7:0]    cur_px_i,
  input logic [CW-1:0] pos_x_q,
  input logic [CW-1:0] pos_y_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!pix_valid_o && pix_rgb_o == 6'd0);
    end
  end

  a_r2_valid_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pix_valid_o == $past(pix_valid_i)));

  a_r3_disabled_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !cur_en_i) |=> (pix_rgb_o == $past(pix_rgb_i)));

  a_r4_outside_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !hit_i) |=> (pix_rgb_o == $past(pix_rgb_i)));

  a_r6_alpha_cursor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && hit_i && cur_px_i[7:6] == 2'd0) |=> (pix_rgb_o == $past(cur_px_i[5:0])));

  a_r6_alpha_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && hit_i && cur_px_i[7:6] == 2'd3) |=> (pix_rgb_o == $past(pix_rgb_i)));

  a_r10_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> (pos_x_q == $past(pos_x_q) && pos_y_q == $past(pos_y_q)));

  a_r10_pos_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (pos_x_q == $past(pos_x_i) && pos_y_q == $past(pos_y_i)));
endmodule

bind ptr_overlay ptr_overlay_chk #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cur_en_i     (cur_en_i),
  .frame_start_i(frame_start_i),
  .pos_x_i      (pos_x_i),
  .pos_y_i      (pos_y_i),
  .pix_valid_i  (pix_valid_i),
  .pix_rgb_i    (pix_rgb_i),
  .pix_valid_o  (pix_valid_o),
  .pix_rgb_o    (pix_rgb_o),
  .hit_i        (hit_w),
  .cur_px_i     (cur_px_w),
  .pos_x_q      (pos_x_q),
  .pos_y_q      (pos_y_q)
);

// File: tb/tb_ptr_overlay.sv
module tb_ptr_overlay;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cur_en_i = 1'b0, cur_big_i = 1'b0, cur_dbl_i = 1'b0, frame_start_i = 1'b0;
  logic [7:0] pos_x_i = '0, pos_y_i = '0;
  logic       ram_we_i = 1'b0;
  logic [7:0] ram_addr_i = '0, ram_wdata_i = '0;
  logic       pix_valid_i = 1'b0;
  logic [7:0] pix_x_i = '0, pix_y_i = '0;
  logic [5:0] pix_rgb_i = '0;
  logic       pix_valid_o;
  logic [5:0] pix_rgb_o;

  always #5 clk_i = ~clk_i;

  ptr_overlay dut (.*);

  int   n_chk = 0, n_err = 0, n_push = 0, n_out = 0;
  bit   done = 1'b0;
  logic [7:0] model_mem [256];
  int   m_px = 0, m_py = 0;
  logic [5:0] exp_q [$];
  string      tag_q [$];

  function automatic int mix(int a, int c, int f);
    case (a)
      0: return c;
      1: return (2*c + f) / 3;
      2: return (c + 2*f) / 3;
      default: return f;
    endcase
  endfunction

  function automatic logic [5:0] expect_px(int x, int y, logic [5:0] fb);
    int side, dx, dy, ad, a;
    logic [7:0] c;
    logic [5:0] r;
    side = cur_big_i ? 16 : 8;
    dx = x - m_px;
    dy = y - m_py;
    if (!cur_en_i || dx < 0 || dy < 0 || dx >= side || dy >= side) return fb;
    if (cur_big_i && cur_dbl_i) ad = (dy/2)*8 + dx/2;
    else if (cur_big_i)         ad = dy*16 + dx;
    else                        ad = dy*8 + dx;
    c = model_mem[ad];
    a = int'(c[7:6]);
    r[5:4] = 2'(mix(a, int'(c[5:4]), int'(fb[5:4])));
    r[3:2] = 2'(mix(a, int'(c[3:2]), int'(fb[3:2])));
    r[1:0] = 2'(mix(a, int'(c[1:0]), int'(fb[1:0])));
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit pv, int x, int y, logic [5:0] rgb,
                      bit wr, int wa, logic [7:0] wd, bit sof, string tag);
    @(negedge clk_i);
    pix_valid_i   = pv;
    pix_x_i       = 8'(x);
    pix_y_i       = 8'(y);
    pix_rgb_i     = rgb;
    ram_we_i      = wr;
    ram_addr_i    = 8'(wa);
    ram_wdata_i   = wd;
    frame_start_i = sof;
    if (wr) model_mem[wa] = wd;
    if (pv) begin
      exp_q.push_back(expect_px(x, y, rgb));
      tag_q.push_back(tag);
      n_push++;
    end
    if (sof) begin
      m_px = int'(pos_x_i);
      m_py = int'(pos_y_i);
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 6'd0, 0, 0, 8'd0, 0, "");
  endtask

  task automatic wr(int a, logic [7:0] d);
    step(0, 0, 0, 6'd0, 1, a, d, 0, "");
  endtask

  task automatic new_frame(int x, int y);
    idle();
    pos_x_i = 8'(x);
    pos_y_i = 8'(y);
    step(0, 0, 0, 6'd0, 0, 0, 8'd0, 1, "");
  endtask

  task automatic scan(int x0, int x1, int y0, int y1, string tag);
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++)
        step(1, x, y, 6'((x*5 + y*3) & 63), 0, 0, 8'd0, 0, tag);
    idle();
  endtask

  // Monitor: compare each produced pixel with the queued expectation
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && pix_valid_o) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected output", 1, 0);
        end else begin
          logic [5:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(pix_rgb_o == e, t, int'(pix_rgb_o), int'(e));
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(pix_valid_o == 1'b0 && pix_rgb_o == 6'd0, "R1 reset state",
          int'({pix_valid_o, pix_rgb_o}), 0);
    rst_ni = 1'b1;
    idle();

    // Fill pointer RAM with an address-dependent pattern
    for (int i = 0; i < 256; i++) wr(i, 8'((i*73 + 29) & 255));

    cur_en_i = 1'b1;
    new_frame(10, 20);
    scan(6, 21, 17, 30, "R5 base addressing");     // also R4 outside pixels

    // R6 and R7: crafted alpha bytes at row 0
    wr(0, 8'b00_10_01_11);
    wr(1, 8'b11_11_11_11);
    wr(2, 8'b01_11_00_10);
    wr(3, 8'b10_11_00_10);
    wr(4, 8'b01_00_11_01);
    wr(5, 8'b10_00_11_01);
    step(1, 10, 20, 6'b01_10_00, 0, 0, 8'd0, 0, "R6 alpha0");
    step(1, 11, 20, 6'b01_10_00, 0, 0, 8'd0, 0, "R6 alpha3");
    step(1, 12, 20, 6'b00_11_01, 0, 0, 8'd0, 0, "R7 alpha1");
    step(1, 13, 20, 6'b00_11_01, 0, 0, 8'd0, 0, "R7 alpha2");
    step(1, 14, 20, 6'b11_00_10, 0, 0, 8'd0, 0, "R7 alpha1");
    step(1, 15, 20, 6'b11_00_10, 0, 0, 8'd0, 0, "R7 alpha2");
    idle();

    // R11: write colliding with a same-cycle read
    step(1, 12, 21, 6'd7, 1, 10, 8'b00_01_10_11, 0, "R11 write wins");
    step(1, 12, 21, 6'd7, 0, 0, 8'd0, 0, "R11 data kept");
    idle();

    cur_en_i = 1'b0;
    scan(8, 19, 19, 29, "R3 disabled");
    cur_en_i = 1'b1;

    // R10: position change without frame start is ignored
    pos_x_i = 8'd60;
    pos_y_i = 8'd60;
    scan(8, 12, 20, 22, "R10 no reload");
    step(1, 60, 60, 6'd9, 0, 0, 8'd0, 0, "R10 no reload");
    new_frame(60, 60);
    scan(58, 62, 59, 61, "R10 reloaded");

    cur_big_i = 1'b1;
    new_frame(100, 100);
    scan(98, 117, 98, 117, "R8 big addressing");

    cur_dbl_i = 1'b1;
    scan(98, 117, 98, 117, "R9 doubled");

    cur_big_i = 1'b0;
    scan(98, 109, 98, 109, "R9 dbl ignored in base");
    cur_dbl_i = 1'b0;

    cur_big_i = 1'b1;
    new_frame(250, 250);
    scan(244, 255, 246, 255, "R4 edge clip");
    scan(0, 5, 0, 5, "R4 no wrap");

    repeat (4) idle();
    check(exp_q.size() == 0 && n_out == n_push, "R2 output count",
          n_out, n_push);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule